// File: doc/BRIEF.md
# Flash Command Sequence Checker

This block is the front end of a flash controller. Software starts a program or erase operation with three bus writes, always in this order. First it writes one data word to an address in the array. Next it writes a command code to the command register. Last it writes 1 to the buffer-empty bit of the status register to launch the operation. The block checks the order, alignment, security and protection of each step. When a rule is broken it drops the partial sequence and raises one of two flags: an access-error flag or a protection-violation flag.

Once an operation is launched, a busy counter stands in for the array algorithm. While an operation runs, one further burst-program command may be queued behind it. That command starts as soon as the running one ends. If stop mode is entered while an operation is running, the operation is aborted and the queued command is discarded. The operation interface (`op_start`, `op_cmd`, `op_addr`, `op_data`) shows each command at the moment it begins.

Top module: `flash_cmd_checker`

## Requirements
- R1: After reset, buffer-empty and command-complete read 1, both error flags read 0, and a read of the status register (register index 2) returns 0x000000C0. The register index is `bus_addr[3:2]`. The status bits are: bit 7 buffer-empty, bit 6 command-complete, bit 1 protection violation, bit 0 access error.
- R2: An array write made before any write to the divider register (index 0) sets the access-error flag and starts no sequence.
- R3: An array write must have size code 2 (full word) and `bus_addr[1:0]` equal to 0. A byte write (code 0), a halfword write (code 1) or a misaligned address sets the access-error flag.
- R4: Each of these sets the access-error flag and abandons the sequence:
  - a second array write after an accepted array write;
  - a write to any register other than the command register (index 3) after an accepted array write.
  A register write made this way has no effect on configuration.
- R5: After a command is accepted, only a write to the status register with bit 7 = 1 launches it. An array write, a write to any other register, or a status write with bit 7 = 0 sets the access-error flag and abandons the sequence.
- R6: The known command codes are 0x05 erase-verify, 0x20 program, 0x25 burst program, 0x40 sector erase and 0x41 mass erase. Any other code sets the protection-violation flag if the captured address is protected, and otherwise sets the access-error flag.
- R7: While an operation runs with the buffer empty, only code 0x25 is accepted; any other code sets the access-error flag. A burst command launched during a run clears buffer-empty. That command starts when the running operation ends, and buffer-empty then returns to 1.
- R8: When `secure_en` is 1 and `bus_trusted` is 0, any command other than 0x05 or 0x41 sets the access-error flag.
- R9: A valid command write sets the protection-violation flag and abandons the sequence when:
  - the command is program or burst program (0x20 or 0x25) and the captured address is protected;
  - the command is sector erase (0x40) and the captured address is protected;
  - the command is mass erase (0x41) and protection is enabled.
  The protection register (index 1) holds the enable in bit 31 and the boundary address in its low ADDR_W bits. An address is protected when protection is enabled and the address is at or above the boundary.
- R10: Raising `stop_req` while command-complete is 0 aborts the operation. After that edge, command-complete and buffer-empty are 1 and the access-error flag is set. A queued burst command never starts.
- R11: Reads never set either error flag. An array read while an operation runs returns all ones; at other times it returns zero.
- R12: Writing 1 to status bit 0 or bit 1 clears that flag. While the access-error flag is set, a valid array write starts no sequence.
- R13: A launch with no operation running pulses `op_start` for one cycle with the captured command, address and data. Command-complete then stays 0 for exactly LAT cycles.
- R14: If a launch write lands in the cycle in which the running operation expires, the new command starts in the next cycle and command-complete stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Single-cycle bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_array | input | 1 | 1 = array space, 0 = register space |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the register |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | DATA_W | Write data |
| bus_trusted | input | 1 | Access comes from a secure source (not the debug port) |
| secure_en | input | 1 | Security is active |
| stop_req | input | 1 | Stop-mode entry |
| bus_rdata | output | DATA_W | Read data (combinational) |
| acc_err | output | 1 | Access-error flag |
| prot_viol | output | 1 | Protection-violation flag |
| buf_empty | output | 1 | Command buffer empty |
| cmd_done | output | 1 | No operation running |
| op_start | output | 1 | One-cycle pulse when an operation begins |
| op_cmd | output | 8 | Command code of the starting operation |
| op_addr | output | ADDR_W | Address of the starting operation |
| op_data | output | DATA_W | Data of the starting operation |

## Verification
Two events can land in the same cycle: the busy counter expiring, and a launch write for a burst command prepared during the run. The bench counts cycles from the first launch and places the second launch exactly on the expiry edge. It expects command-complete to stay low and the second command to appear on the operation interface in the next cycle, with no gap. A scoreboard queue holds every operation expected to start, so an early, late, missing or extra start is reported. The same queue shows that a burst command queued before a stop-mode abort never starts.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_ADDR = 2'd1,
      SQ_CMD  = 2'd2
   } seq_state_e;

   localparam logic [7:0] OP_ERASE_VFY = 8'h05;
   localparam logic [7:0] OP_PROGRAM   = 8'h20;
   localparam logic [7:0] OP_BURST     = 8'h25;
   localparam logic [7:0] OP_SECTOR    = 8'h40;
   localparam logic [7:0] OP_MASS      = 8'h41;

   localparam logic [1:0] RG_DIV  = 2'd0;
   localparam logic [1:0] RG_PROT = 2'd1;
   localparam logic [1:0] RG_STAT = 2'd2;
   localparam logic [1:0] RG_CMD  = 2'd3;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;

   localparam int ST_AE    = 0;
   localparam int ST_PV    = 1;
   localparam int ST_DONE  = 6;
   localparam int ST_EMPTY = 7;

   function automatic logic op_known(input logic [7:0] code);
      return (code == OP_ERASE_VFY) || (code == OP_PROGRAM) || (code == OP_BURST) ||
             (code == OP_SECTOR) || (code == OP_MASS);
   endfunction

endpackage

// File: rtl/fcs_seq.sv
module fcs_seq
   import fcs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arr_wr,
   input  logic              reg_wr,
   input  logic [1:0]        sel,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_trusted,
   input  logic              secure_en,
   input  logic              div_set,
   input  logic              prot_en,
   input  logic [ADDR_W-1:0] prot_bound,
   input  logic              running,
   input  logic              buf_empty,
   input  logic              acc_err,
   input  logic              abort,
   output logic              set_ae,
   output logic              set_pv,
   output logic              launch,
   output logic              cfg_we,
   output logic [7:0]        cap_cmd,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [DATA_W-1:0] cap_data
);

   seq_state_e state, nxt;
   logic       cap_en, cmd_en, prot_hit, misfit;
   logic [7:0] code;

   assign code     = bus_wdata[7:0];
   assign prot_hit = prot_en && (cap_addr >= prot_bound);
   assign misfit   = (bus_size != SZ_WORD) || (bus_addr[1:0] != 2'b00);
   assign cfg_we   = reg_wr && (state == SQ_IDLE) && !abort;

   always_comb begin
      nxt    = state;
      set_ae = 1'b0;
      set_pv = 1'b0;
      launch = 1'b0;
      cap_en = 1'b0;
      cmd_en = 1'b0;
      unique case (state)
         SQ_IDLE: begin
            if (arr_wr) begin
               if (!div_set || acc_err || !buf_empty || misfit) set_ae = 1'b1;
               else begin
                  cap_en = 1'b1;
                  nxt    = SQ_ADDR;
               end
            end else if (reg_wr && sel == RG_CMD) begin
               set_ae = 1'b1;
            end
         end
         SQ_ADDR: begin
            if (arr_wr || (reg_wr && sel != RG_CMD)) begin
               set_ae = 1'b1;
               nxt    = SQ_IDLE;
            end else if (reg_wr) begin
               nxt = SQ_IDLE;
               if (!op_known(code)) begin
                  if (prot_hit) set_pv = 1'b1;
                  else          set_ae = 1'b1;
               end else if (running && buf_empty && code != OP_BURST) begin
                  set_ae = 1'b1;
               end else if (secure_en && !bus_trusted &&
                            code != OP_ERASE_VFY && code != OP_MASS) begin
                  set_ae = 1'b1;
               end else if (((code == OP_PROGRAM || code == OP_BURST || code == OP_SECTOR) && prot_hit) ||
                            (code == OP_MASS && prot_en)) begin
                  set_pv = 1'b1;
               end else begin
                  cmd_en = 1'b1;
                  nxt    = SQ_CMD;
               end
            end
         end
         SQ_CMD: begin
            if (arr_wr || reg_wr) begin
               nxt = SQ_IDLE;
               if (reg_wr && sel == RG_STAT && bus_wdata[ST_EMPTY]) launch = 1'b1;
               else                                                 set_ae = 1'b1;
            end
         end
         default: nxt = SQ_IDLE;
      endcase
      if (abort) begin
         nxt    = SQ_IDLE;
         launch = 1'b0;
         cap_en = 1'b0;
         cmd_en = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         cap_cmd  <= '0;
         cap_addr <= '0;
         cap_data <= '0;
      end else begin
         state <= nxt;
         if (cap_en) begin
            cap_addr <= bus_addr;
            cap_data <= bus_wdata;
         end
         if (cmd_en) cap_cmd <= code;
      end
   end

   // R2: no sequence opens before the divider is written
   a_r2_div_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE && arr_wr && !div_set) |=> (state == SQ_IDLE));

   // R12: a pending access error blocks the start of a sequence
   a_r12_blocked_start: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_IDLE && arr_wr && acc_err) |=> (state == SQ_IDLE));

   // R5: a sequence never lingers after the launch write
   a_r5_launch_closes: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> (state == SQ_IDLE));

endmodule

// File: rtl/fcs_engine.sv
module fcs_engine #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int LAT    = 8,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [7:0]        l_cmd,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_data,
   input  logic              set_ae,
   input  logic              set_pv,
   input  logic              clr_ae,
   input  logic              clr_pv,
   input  logic              stop_req,
   output logic              cmd_done,
   output logic              buf_empty,
   output logic              acc_err,
   output logic              prot_viol,
   output logic              running,
   output logic              abort,
   output logic              op_start,
   output logic [7:0]        op_cmd,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data
);

   logic              done_q, be_q, ae_q, pv_q, pend_q, start_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [7:0]        cur_cmd_q, pend_cmd_q;
   logic [ADDR_W-1:0] cur_addr_q, pend_addr_q;
   logic [DATA_W-1:0] cur_data_q, pend_data_q;
   logic              expire;

   assign running = !done_q;
   assign expire  = running && (cnt_q == '0);
   assign abort   = stop_req && running;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q      <= 1'b1;
         be_q        <= 1'b1;
         ae_q        <= 1'b0;
         pv_q        <= 1'b0;
         pend_q      <= 1'b0;
         start_q     <= 1'b0;
         cnt_q       <= '0;
         cur_cmd_q   <= '0;
         cur_addr_q  <= '0;
         cur_data_q  <= '0;
         pend_cmd_q  <= '0;
         pend_addr_q <= '0;
         pend_data_q <= '0;
      end else begin
         start_q <= 1'b0;
         if (set_ae)      ae_q <= 1'b1;
         else if (clr_ae) ae_q <= 1'b0;
         if (set_pv)      pv_q <= 1'b1;
         else if (clr_pv) pv_q <= 1'b0;
         if (running && !expire) cnt_q <= cnt_q - 1'b1;

         if (abort) begin
            done_q <= 1'b1;
            be_q   <= 1'b1;
            pend_q <= 1'b0;
            ae_q   <= 1'b1;
         end else if (launch && (!running || expire)) begin
            cur_cmd_q  <= l_cmd;
            cur_addr_q <= l_addr;
            cur_data_q <= l_data;
            cnt_q      <= CNT_W'(LAT - 1);
            done_q     <= 1'b0;
            start_q    <= 1'b1;
         end else if (launch) begin
            pend_q      <= 1'b1;
            be_q        <= 1'b0;
            pend_cmd_q  <= l_cmd;
            pend_addr_q <= l_addr;
            pend_data_q <= l_data;
         end else if (expire && pend_q) begin
            cur_cmd_q  <= pend_cmd_q;
            cur_addr_q <= pend_addr_q;
            cur_data_q <= pend_data_q;
            cnt_q      <= CNT_W'(LAT - 1);
            pend_q     <= 1'b0;
            be_q       <= 1'b1;
            start_q    <= 1'b1;
         end else if (expire) begin
            done_q <= 1'b1;
         end
      end
   end

   assign cmd_done  = done_q;
   assign buf_empty = be_q;
   assign acc_err   = ae_q;
   assign prot_viol = pv_q;
   assign op_start  = start_q;
   assign op_cmd    = cur_cmd_q;
   assign op_addr   = cur_addr_q;
   assign op_data   = cur_data_q;

   // R7: a queued command exists only behind a running one
   a_r7_queue_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !done_q);
   // R7: a full buffer is always the queued burst
   a_r7_full_is_queued: assert property (@(posedge clk) disable iff (!rst_n)
      !be_q |-> pend_q);
   // R10: stop during a run aborts everything
   a_r10_stop_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !done_q) |=> (done_q && ae_q && be_q && !pend_q));
   // R14: launch on the expiry edge chains without a gap
   a_r14_chain: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && expire && !stop_req) |=> (!done_q && start_q));
   // R13: a start pulse always coincides with a running operation
   a_r13_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> !done_q);

endmodule

// File: rtl/fcs_cfg.sv
module fcs_cfg
   import fcs_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int DIV_W       = 7,
   parameter bit READ_POISON = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        sel,
   input  logic [DIV_W-1:0]  w_div,
   input  logic              w_prot_en,
   input  logic [ADDR_W-1:0] w_bound,
   input  logic              rd_req,
   input  logic              rd_array,
   input  logic              running,
   input  logic              acc_err,
   input  logic              prot_viol,
   input  logic              cmd_done,
   input  logic              buf_empty,
   input  logic [7:0]        cap_cmd,
   output logic              div_set,
   output logic              prot_en,
   output logic [ADDR_W-1:0] prot_bound,
   output logic [DATA_W-1:0] rdata
);

   logic [DIV_W-1:0]  div_q;
   logic [DATA_W-1:0] fill, stat_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q      <= '0;
         div_set    <= 1'b0;
         prot_en    <= 1'b0;
         prot_bound <= '0;
      end else if (we) begin
         if (sel == RG_DIV) begin
            div_q   <= w_div;
            div_set <= 1'b1;
         end
         if (sel == RG_PROT) begin
            prot_en    <= w_prot_en;
            prot_bound <= w_bound;
         end
      end
   end

   generate
      if (READ_POISON) begin : g_fill_ones
         assign fill = '1;
         // R11: array read during a run yields all ones
         a_r11_busy_fill: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req && rd_array && running) |-> (rdata == '1));
      end else begin : g_fill_zero
         assign fill = '0;
      end
   endgenerate

   always_comb begin
      stat_word           = '0;
      stat_word[ST_AE]    = acc_err;
      stat_word[ST_PV]    = prot_viol;
      stat_word[ST_DONE]  = cmd_done;
      stat_word[ST_EMPTY] = buf_empty;
      if (rd_array) rdata = running ? fill : '0;
      else begin
         unique case (sel)
            RG_DIV:  rdata = DATA_W'(div_q);
            RG_PROT: rdata = {prot_en, {(DATA_W-1-ADDR_W){1'b0}}, prot_bound};
            RG_STAT: rdata = stat_word;
            default: rdata = DATA_W'(cap_cmd);
         endcase
      end
   end

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker
   import fcs_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int DIV_W       = 7,
   parameter int LAT         = 8,
   parameter bit READ_POISON = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic              bus_array,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_trusted,
   input  logic              secure_en,
   input  logic              stop_req,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              acc_err,
   output logic              prot_viol,
   output logic              buf_empty,
   output logic              cmd_done,
   output logic              op_start,
   output logic [7:0]        op_cmd,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data
);

   localparam int CNT_W = (LAT > 2) ? $clog2(LAT) : 1;

   generate
      if (LAT < 2)                         begin : g_bad_lat  $error("LAT must be at least 2");            end
      if (DATA_W != 32)                    begin : g_bad_data $error("DATA_W must be 32");                  end
      if (ADDR_W < 8 || ADDR_W > DATA_W-1) begin : g_bad_addr $error("ADDR_W out of range");                end
      if (DIV_W < 1 || DIV_W > DATA_W-1)   begin : g_bad_div  $error("DIV_W out of range");                 end
   endgenerate

   logic              arr_wr, reg_wr, stat_wr;
   logic [1:0]        sel;
   logic              set_ae, set_pv, launch, cfg_we, running, abort;
   logic              div_set, prot_en;
   logic [ADDR_W-1:0] prot_bound, cap_addr;
   logic [7:0]        cap_cmd;
   logic [DATA_W-1:0] cap_data;

   assign arr_wr  = bus_req && bus_wr && bus_array;
   assign reg_wr  = bus_req && bus_wr && !bus_array;
   assign sel     = bus_addr[3:2];
   assign stat_wr = reg_wr && (sel == RG_STAT);

   fcs_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .arr_wr(arr_wr), .reg_wr(reg_wr), .sel(sel),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_trusted(bus_trusted), .secure_en(secure_en), .div_set(div_set),
      .prot_en(prot_en), .prot_bound(prot_bound), .running(running),
      .buf_empty(buf_empty), .acc_err(acc_err), .abort(abort),
      .set_ae(set_ae), .set_pv(set_pv), .launch(launch), .cfg_we(cfg_we),
      .cap_cmd(cap_cmd), .cap_addr(cap_addr), .cap_data(cap_data)
   );

   fcs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(LAT), .CNT_W(CNT_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .launch(launch), .l_cmd(cap_cmd),
      .l_addr(cap_addr), .l_data(cap_data), .set_ae(set_ae), .set_pv(set_pv),
      .clr_ae(stat_wr && bus_wdata[ST_AE]), .clr_pv(stat_wr && bus_wdata[ST_PV]),
      .stop_req(stop_req), .cmd_done(cmd_done), .buf_empty(buf_empty),
      .acc_err(acc_err), .prot_viol(prot_viol), .running(running), .abort(abort),
      .op_start(op_start), .op_cmd(op_cmd), .op_addr(op_addr), .op_data(op_data)
   );

   fcs_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .READ_POISON(READ_POISON)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(sel),
      .w_div(bus_wdata[DIV_W-1:0]), .w_prot_en(bus_wdata[DATA_W-1]),
      .w_bound(bus_wdata[ADDR_W-1:0]), .rd_req(bus_req && !bus_wr),
      .rd_array(bus_array), .running(running), .acc_err(acc_err),
      .prot_viol(prot_viol), .cmd_done(cmd_done), .buf_empty(buf_empty),
      .cap_cmd(cap_cmd), .div_set(div_set), .prot_en(prot_en),
      .prot_bound(prot_bound), .rdata(bus_rdata)
   );

   // R11: an access error only ever follows a write or a stop request
   a_r11_quiet_reads: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_err) |-> ($past(bus_req && bus_wr) || $past(stop_req)));
   // R9: a protection violation only follows a register write
   a_r9_pv_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_viol) |-> $past(bus_req && bus_wr && !bus_array));

endmodule

// File: tb/flash_cmd_checker_test.sv
module flash_cmd_checker_test;
   import fcs_pkg::*;

   localparam int LAT = 8;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_wr = 1'b0, bus_array = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_trusted = 1'b1, secure_en = 1'b0, stop_req = 1'b0;
   logic [31:0] bus_rdata, op_data;
   logic        acc_err, prot_viol, buf_empty, cmd_done, op_start;
   logic [7:0]  op_cmd;
   logic [15:0] op_addr;

   int          nchk = 0, nerr = 0;
   bit          ended = 1'b0;
   logic [55:0] expq[$];
   logic [31:0] rv;

   always #10 clk = ~clk;

   flash_cmd_checker #(.LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_array(bus_array), .bus_addr(bus_addr), .bus_size(bus_size),
      .bus_wdata(bus_wdata), .bus_trusted(bus_trusted), .secure_en(secure_en),
      .stop_req(stop_req), .bus_rdata(bus_rdata), .acc_err(acc_err),
      .prot_viol(prot_viol), .buf_empty(buf_empty), .cmd_done(cmd_done),
      .op_start(op_start), .op_cmd(op_cmd), .op_addr(op_addr), .op_data(op_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: every start must match the head of the expectation queue
   always @(negedge clk) begin
      if (rst_n && op_start) begin
         nchk++;
         if (expq.size() == 0) begin
            nerr++;
            $display("FAIL R13 unexpected start: actual %h expected none", {op_cmd, op_addr, op_data});
         end else begin
            logic [55:0] e;
            e = expq.pop_front();
            if ({op_cmd, op_addr, op_data} !== e) begin
               nerr++;
               $display("FAIL R13 start: actual %h expected %h", {op_cmd, op_addr, op_data}, e);
            end
         end
      end
   end

   task automatic wr(input logic arr, input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d);
      bus_req = 1'b1; bus_wr = 1'b1; bus_array = arr; bus_addr = a; bus_size = sz; bus_wdata = d;
      @(posedge clk); @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic regw(input logic [1:0] idx, input logic [31:0] d);
      wr(1'b0, {12'h000, idx, 2'b00}, SZ_WORD, d);
   endtask

   task automatic rd(input logic arr, input logic [15:0] a, output logic [31:0] d);
      bus_req = 1'b1; bus_wr = 1'b0; bus_array = arr; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_req = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clr();
      regw(RG_STAT, 32'h0000_0083);
   endtask

   task automatic seq(input logic [15:0] a, input logic [31:0] d, input logic [7:0] c);
      wr(1'b1, a, SZ_WORD, d);
      regw(RG_CMD, {24'h0, c});
   endtask

   task automatic go();
      regw(RG_STAT, 32'h0000_0080);
   endtask

   task automatic expect_op(input logic [7:0] c, input logic [15:0] a, input logic [31:0] d);
      expq.push_back({c, a, d});
   endtask

   initial begin
      #(20 * 150000);
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      if (!ended) begin
         ended = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
      end
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      rd(1'b0, 16'h0008, rv);
      chk("R1 status word", rv, 32'h0000_00C0);
      chk("R1 flags", {30'b0, acc_err, prot_viol}, 32'h0);

      // R2 array write before divider
      wr(1'b1, 16'h1000, SZ_WORD, 32'h1111_1111);
      chk("R2 no divider", acc_err, 1'b1);
      clr();
      chk("R12 w1c clears access error", acc_err, 1'b0);
      regw(RG_DIV, 32'h5);

      // R3 size and alignment
      wr(1'b1, 16'h1000, SZ_BYTE, 32'h1);
      chk("R3 byte", acc_err, 1'b1); clr();
      wr(1'b1, 16'h1000, SZ_HALF, 32'h1);
      chk("R3 half", acc_err, 1'b1); clr();
      wr(1'b1, 16'h1002, SZ_WORD, 32'h1);
      chk("R3 misaligned", acc_err, 1'b1); clr();

      // R4 second array write / other register
      wr(1'b1, 16'h1000, SZ_WORD, 32'h1);
      wr(1'b1, 16'h1004, SZ_WORD, 32'h2);
      chk("R4 second array write", acc_err, 1'b1); clr();
      wr(1'b1, 16'h1000, SZ_WORD, 32'h1);
      regw(RG_PROT, 32'h8000_0010);
      chk("R4 foreign register", acc_err, 1'b1); clr();
      rd(1'b0, 16'h0004, rv);
      chk("R4 register write discarded", rv, 32'h0);
      regw(RG_CMD, 32'h20);
      chk("R4 sequence abandoned", acc_err, 1'b1); clr();

      // R5 after command
      seq(16'h1000, 32'h1, OP_PROGRAM);
      regw(RG_DIV, 32'h5);
      chk("R5 other register", acc_err, 1'b1); clr();
      seq(16'h1000, 32'h1, OP_PROGRAM);
      regw(RG_STAT, 32'h0);
      chk("R5 zero to buffer-empty", acc_err, 1'b1); clr();
      seq(16'h1000, 32'h1, OP_PROGRAM);
      wr(1'b1, 16'h1000, SZ_WORD, 32'h1);
      chk("R5 array after command", acc_err, 1'b1); clr();
      chk("R5 no start", cmd_done, 1'b1);

      // R13 normal launch and latency, R11 reads
      seq(16'h1000, 32'hA5A5_0001, OP_PROGRAM);
      expect_op(OP_PROGRAM, 16'h1000, 32'hA5A5_0001);
      go();
      chk("R13 busy after launch", cmd_done, 1'b0);
      rd(1'b1, 16'h1000, rv);
      chk("R11 busy array read", rv, 32'hFFFF_FFFF);
      rd(1'b0, 16'h0008, rv);
      chk("R11 status during run", rv, 32'h0000_0080);
      idle(LAT - 3);
      chk("R13 still busy at LAT-1", cmd_done, 1'b0);
      idle(1);
      chk("R13 done at LAT", cmd_done, 1'b1);
      rd(1'b1, 16'h1000, rv);
      chk("R11 idle array read", rv, 32'h0);
      chk("R11 reads set no flag", {30'b0, acc_err, prot_viol}, 32'h0);

      // R6 invalid codes
      seq(16'h1000, 32'h1, 8'h33);
      chk("R6 invalid unprotected", {30'b0, acc_err, prot_viol}, 32'h2); clr();
      regw(RG_PROT, 32'h8000_8000);
      seq(16'h9000, 32'h1, 8'h33);
      chk("R6 invalid protected", {30'b0, acc_err, prot_viol}, 32'h1); clr();
      chk("R12 w1c clears violation", prot_viol, 1'b0);

      // R9 protection
      seq(16'h8000, 32'h1, OP_PROGRAM);
      chk("R9 program at boundary", prot_viol, 1'b1); clr();
      seq(16'h9000, 32'h1, OP_SECTOR);
      chk("R9 sector protected", prot_viol, 1'b1); clr();
      seq(16'h1000, 32'h1, OP_MASS);
      chk("R9 mass with protection", prot_viol, 1'b1); clr();
      seq(16'h7FFC, 32'h7, OP_PROGRAM);
      chk("R9 below boundary accepted", {30'b0, acc_err, prot_viol}, 32'h0);
      expect_op(OP_PROGRAM, 16'h7FFC, 32'h7);
      go(); idle(LAT + 1);
      regw(RG_PROT, 32'h0);

      // R8 security
      secure_en = 1'b1; bus_trusted = 1'b0;
      seq(16'h1000, 32'h1, OP_PROGRAM);
      chk("R8 untrusted program", acc_err, 1'b1); clr();
      seq(16'h1000, 32'h3, OP_ERASE_VFY);
      chk("R8 untrusted erase verify", acc_err, 1'b0);
      expect_op(OP_ERASE_VFY, 16'h1000, 32'h3);
      go(); idle(LAT + 1);
      bus_trusted = 1'b1;
      seq(16'h1010, 32'h4, OP_PROGRAM);
      chk("R8 trusted program", acc_err, 1'b0);
      expect_op(OP_PROGRAM, 16'h1010, 32'h4);
      go(); idle(LAT + 1);
      secure_en = 1'b0;

      // R7 queueing during a run
      seq(16'h1000, 32'hB0, OP_PROGRAM);
      expect_op(OP_PROGRAM, 16'h1000, 32'hB0);
      go();
      seq(16'h1100, 32'hB1, OP_SECTOR);
      chk("R7 non-burst while busy", acc_err, 1'b1);
      clr();
      seq(16'h1200, 32'hB2, OP_BURST);
      expect_op(OP_BURST, 16'h1200, 32'hB2);
      go();
      chk("R7 buffer full after queue", buf_empty, 1'b0);
      idle(3);
      chk("R7 buffer empty after queued start", {30'b0, buf_empty, cmd_done}, 32'h2);
      idle(LAT + 2);
      chk("R7 both done", cmd_done, 1'b1);

      // R14 launch on the expiry edge
      seq(16'h1000, 32'hC0, OP_PROGRAM);
      expect_op(OP_PROGRAM, 16'h1000, 32'hC0);
      go();
      seq(16'h1300, 32'hC1, OP_BURST);
      expect_op(OP_BURST, 16'h1300, 32'hC1);
      idle(LAT - 3);
      go();
      chk("R14 no gap", {30'b0, cmd_done, op_start}, 32'h1);
      idle(LAT);
      chk("R14 chained op length", cmd_done, 1'b1);

      // R10 stop while running with a queued burst
      seq(16'h1000, 32'hD0, OP_PROGRAM);
      expect_op(OP_PROGRAM, 16'h1000, 32'hD0);
      go();
      seq(16'h1400, 32'hD1, OP_BURST);
      go();
      stop_req = 1'b1;
      @(posedge clk); @(negedge clk);
      stop_req = 1'b0;
      chk("R10 abort state", {29'b0, acc_err, buf_empty, cmd_done}, 32'h7);
      idle(2 * LAT);
      chk("R10 queue discarded", cmd_done, 1'b1);

      // R12 error blocks a new sequence
      wr(1'b1, 16'h1000, SZ_WORD, 32'h9);
      chk("R12 still errored", acc_err, 1'b1);
      clr();
      regw(RG_CMD, {24'h0, OP_PROGRAM});
      chk("R12 no sequence was opened", acc_err, 1'b1);
      clr();

      idle(2);
      chk("R13 all expected starts seen", expq.size(), 32'h0);
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule